// File: doc/BRIEF.md
# Phase-Accumulator Sine and Cosine Generator

This block produces a digital sine sample stream and a cosine sample stream. Both are clocked every cycle and their frequency is set by a tuning word. The tuning word is loaded through a parallel port. On every clock it is added to a wide phase register, and the register wraps at its natural width. The top bits of the phase pick an entry of a sine table that the RTL computes at elaboration. The table is biased by half scale so that every code is non-negative. The codes can therefore drive a unipolar DAC directly.

The output frequency is `inc * f_clk / 2^ACC_W`. A new tuning word changes the frequency on the next clock and leaves the phase where it was. A synchronous clear restarts the phase at zero. A tuning word above half the phase range cannot give two samples per output cycle. Such a word is clipped to half range and a flag reports the clip.

Top module: `dds_sincos_gen`

## Requirements
- R1: On every clock outside reset and clear, the phase register takes its previous value plus the active increment, modulo 2^ACC_W.
- R2: `sin_out` is the table code for the phase address k = phase[ACC_W-1 -: ADDR_W]. The code is round((1 + sin(2πk/2^ADDR_W)) · (2^DATA_W − 1)/2). Phase zero gives half scale (128 for 8 bits), address 2^ADDR_W/4 gives full scale, and address 3·2^ADDR_W/4 gives 0.
- R3: `cos_out` is the table code for address k + 2^ADDR_W/4, wrapped modulo 2^ADDR_W. It comes from the same phase sample and appears in the same cycle as `sin_out`.
- R4: Each output sample appears one clock after the phase value it is taken from. `sample_valid` is 1 from the first clock edge after reset is released, and stays 1 until the next reset.
- R5: A `tune_load` pulse at a clock edge installs the new increment. The first phase step to use it is at the following edge, and the phase is not disturbed by the load.
- R6: A loaded word above 2^(ACC_W−1) is replaced by 2^(ACC_W−1) and sets `tune_clipped`. A word equal to or below that limit is used unchanged and clears `tune_clipped`. The flag holds until the next load.
- R7: `phase_clr` high at a clock edge sets the phase to zero. It takes priority over the accumulation, and it keeps the loaded increment.
- R8: While `rst` is high at a clock edge, the phase and increment become 0, the sample outputs become 0, and `sample_valid` and `tune_clipped` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_load | input | 1 | Load strobe for the tuning word |
| tune_word | input | ACC_W | Phase increment per clock |
| phase_clr | input | 1 | Synchronous phase clear |
| sin_out | output | DATA_W | Biased sine sample |
| cos_out | output | DATA_W | Biased cosine sample |
| sample_valid | output | 1 | Samples on the outputs are valid |
| tune_clipped | output | 1 | Last loaded word exceeded half range |

## Verification
The assertions assume that `tune_load` and `phase_clr` are sampled only on clock edges. They also assume that `rst` is held for at least one edge before any other stimulus counts. The clip assertion assumes any tuning word is possible, so the stimulus includes words above, at and below half range. Inputs are driven only on falling edges. Clear and load are applied both alone and during an active frequency, so the step, clear and hold properties are exercised over wrapping phases.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real TWO_PI = 6.283185307179586;
  localparam real PI     = 3.141592653589793;

  // Biased sine code for table entry idx of a 2^addr_w table.
  function automatic int sine_code(input int idx, input int addr_w, input int data_w);
    int  depth;
    real x, term, s, full, v;
    depth = 1 << addr_w;
    full  = real'((1 << data_w) - 1);
    if ((idx % (depth / 2)) == 0)
      return 1 << (data_w - 1);
    x = TWO_PI * real'(idx) / real'(depth);
    if (x > PI) x = x - TWO_PI;
    term = x;
    s    = x;
    for (int k = 1; k < 14; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      s    = s + term;
    end
    v = (s + 1.0) * full / 2.0 + 0.5;
    if (v < 0.0) v = 0.0;
    if (v > full) v = full;
    return $rtoi(v);
  endfunction

endpackage

// File: rtl/dds_tuning_reg.sv
module dds_tuning_reg #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] word,
  output logic [ACC_W-1:0] inc,
  output logic             clipped
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic             over;
  logic [ACC_W-1:0] inc_q;
  logic             clip_q;

  assign over = (word > HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q  <= '0;
      clip_q <= 1'b0;
    end else if (load) begin
      inc_q  <= over ? HALF : word;
      clip_q <= over;
    end
  end

  assign inc     = inc_q;
  assign clipped = clip_q;

  p_clip_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (load && (word > HALF)) |=> (clipped && inc == HALF));
  p_pass_word_r6: assert property (@(posedge clk) disable iff (rst)
    (load && (word <= HALF)) |=> (!clipped && inc == $past(word)));
  p_hold_inc_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(inc) && $stable(clipped)));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clr) phase_q <= '0;
    else            phase_q <= phase_q + inc;
  end

  assign phase = phase_q;

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (phase == ACC_W'($past(phase) + $past(inc))));
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == '0));

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sin_addr,
  output logic [DATA_W-1:0] sin_data,
  output logic [DATA_W-1:0] cos_data,
  output logic              valid
);
  import dds_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(DEPTH / 4);

  logic [DATA_W-1:0] rom [DEPTH];
  logic [ADDR_W-1:0] cos_addr;
  logic [DATA_W-1:0] sin_q, cos_q;
  logic              valid_q;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = DATA_W'(sine_code(i, ADDR_W, DATA_W));
  end

  assign cos_addr = sin_addr + QUARTER;

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q   <= '0;
      cos_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sin_q   <= rom[sin_addr];
      cos_q   <= rom[cos_addr];
      valid_q <= 1'b1;
    end
  end

  assign sin_data = sin_q;
  assign cos_data = cos_q;
  assign valid    = valid_q;

  p_valid_stays_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);
  p_valid_rises_r4: assert property (@(posedge clk) disable iff (rst)
    !valid |=> valid);

endmodule

// File: rtl/dds_sincos_gen.sv
module dds_sincos_gen #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tune_load,
  input  logic [ACC_W-1:0]  tune_word,
  input  logic              phase_clr,
  output logic [DATA_W-1:0] sin_out,
  output logic [DATA_W-1:0] cos_out,
  output logic              sample_valid,
  output logic              tune_clipped
);
  logic [ACC_W-1:0]  inc;
  logic [ACC_W-1:0]  phase;
  logic [ADDR_W-1:0] addr;

  dds_tuning_reg #(.ACC_W(ACC_W)) u_tune (
    .clk(clk), .rst(rst), .load(tune_load), .word(tune_word),
    .inc(inc), .clipped(tune_clipped)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(phase_clr), .inc(inc), .phase(phase)
  );

  assign addr = phase[ACC_W-1 -: ADDR_W];

  dds_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .rst(rst), .sin_addr(addr),
    .sin_data(sin_out), .cos_data(cos_out), .valid(sample_valid)
  );

  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (!sample_valid && !tune_clipped && sin_out == '0 && cos_out == '0));

  initial begin
    assert (ACC_W >= ADDR_W && ADDR_W >= 2);
  end

endmodule

// File: tb/test_dds_sincos_gen.sv
module test_dds_sincos_gen;
  localparam int ACC_W  = 8;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 1 << (ACC_W - 1);

  typedef struct packed {
    logic [7:0]  word;
    logic        clip;
    logic [7:0]  hold;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd1,   1'b0, 8'd20},
    '{8'd16,  1'b0, 8'd20},
    '{8'd32,  1'b0, 8'd12},
    '{8'd64,  1'b0, 8'd8},
    '{8'd128, 1'b0, 8'd6},
    '{8'd200, 1'b1, 8'd6},
    '{8'd255, 1'b1, 8'd4},
    '{8'd48,  1'b0, 8'd20}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tune_load = 1'b0;
  logic [ACC_W-1:0]  tune_word = '0;
  logic              phase_clr = 1'b0;
  logic [DATA_W-1:0] sin_out, cos_out;
  logic              sample_valid, tune_clipped;

  int n_vec = 0;
  int n_bad = 0;
  int m_phase = 0, m_inc = 0;
  int e_sin = 0, e_cos = 0;
  bit e_valid = 0, e_clip = 0;

  always #4 clk = ~clk;

  dds_sincos_gen #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dds_sincos_gen (
    .clk(clk), .rst(rst), .tune_load(tune_load), .tune_word(tune_word),
    .phase_clr(phase_clr), .sin_out(sin_out), .cos_out(cos_out),
    .sample_valid(sample_valid), .tune_clipped(tune_clipped)
  );

  function automatic int ideal(input int k);
    real v;
    v = (1.0 + $sin(6.283185307179586 * real'(k % DEPTH) / real'(DEPTH))) * 127.5 + 0.5;
    return $rtoi(v);
  endfunction

  // One clock edge: update the requirement model with the inputs seen there.
  task automatic step();
    int a;
    @(posedge clk);
    if (rst) begin
      m_phase = 0; m_inc = 0; e_sin = 0; e_cos = 0; e_valid = 0; e_clip = 0;
    end else begin
      a = m_phase >> (ACC_W - ADDR_W);
      e_sin   = ideal(a);
      e_cos   = ideal(a + DEPTH / 4);
      e_valid = 1;
      m_phase = phase_clr ? 0 : (m_phase + m_inc) % (1 << ACC_W);
      if (tune_load) begin
        m_inc  = (int'(tune_word) > HALF) ? HALF : int'(tune_word);
        e_clip = int'(tune_word) > HALF;
      end
    end
    @(negedge clk);
  endtask

  task automatic check(input string req);
    n_vec++;
    if (int'(sin_out) != e_sin || int'(cos_out) != e_cos ||
        sample_valid != e_valid || tune_clipped != e_clip) begin
      n_bad++;
      $display("FAIL %s: sin=%0d cos=%0d valid=%0b clip=%0b expected sin=%0d cos=%0d valid=%0b clip=%0b",
               req, sin_out, cos_out, sample_valid, tune_clipped, e_sin, e_cos, e_valid, e_clip);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state
    for (int i = 0; i < 3; i++) step();
    check("R8 reset");
    rst = 1'b0;
    // R4: valid after first edge; R2 phase zero -> mid scale, cos full scale
    step(); check("R4 first sample");
    step(); check("R2 idle phase zero");

    // Vector walk: R1 R2 R3 R5 R6
    foreach (VECS[v]) begin
      tune_word = VECS[v].word;
      tune_load = 1'b1;
      step();
      tune_load = 1'b0;
      check("R5 load edge");
      if (tune_clipped != VECS[v].clip) begin
        n_bad++;
        $display("FAIL R6: clip=%0b expected %0b for word %0d", tune_clipped, VECS[v].clip, VECS[v].word);
      end
      for (int c = 0; c < int'(VECS[v].hold); c++) begin
        step(); check("R1 R2 R3 accumulate");
      end
    end

    // R7: clear mid-run keeps increment
    tune_word = 8'd16; tune_load = 1'b1; step(); tune_load = 1'b0; check("R6 unclipped load");
    for (int c = 0; c < 5; c++) begin step(); check("R1 run"); end
    phase_clr = 1'b1; step(); phase_clr = 1'b0; check("R7 clear edge");
    for (int c = 0; c < 6; c++) begin step(); check("R7 after clear"); end

    // R6: exactly half range is not clipped
    tune_word = 8'd128; tune_load = 1'b1; step(); tune_load = 1'b0; check("R6 half range");
    for (int c = 0; c < 4; c++) begin step(); check("R6 half range run"); end

    // R8: reset mid-run, then restart from zero with zero increment
    rst = 1'b1; step(); check("R8 mid-run reset");
    rst = 1'b0;
    for (int c = 0; c < 4; c++) begin step(); check("R8 restart"); end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule